// File: doc/BRIEF.md
# Front-End Word Buffer with Trigger Hold-Off

This block sits between one front-end serial receiver and a memory writer that is shared by many sources. Each deserialised 32-bit word arrives on a push port and waits in a 64-entry first-in first-out store. The memory writer takes words through a show-ahead pop port. Because the writer serves eighteen sources in turn, it drains this buffer at most once every eighteen system clock cycles. The buffer therefore has to absorb bursts and tell the trigger logic when to stop sending new triggers.

A hold-off output named `inhibit` has hysteresis. It rises on the clock edge at which the fill level reaches half the depth, and it stays high until the buffer has been fully drained. A second, higher watermark protects event bookkeeping: from that level up, the block admits only group-leader and group-trailer words, so every group that has started can still be closed. When all entries are occupied, every push without a matching pop is lost, and a sticky flag records the loss. A synchronous global reset empties the buffer and clears all flags.

Top module: `frontend_word_buffer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `empty`=1, `half_full`=0, `inhibit`=0 and `overflow`=0.
- R2: Words leave in the order they were admitted. Whenever `empty`=0, `pop_data` shows the oldest stored word, and a cycle with `pop_req`=1 removes it.
- R3: `empty` is 1 exactly when the fill level is 0. `half_full` is 1 exactly when the fill level is 32 or more. Both reflect the level after the most recent clock edge.
- R4: `inhibit` becomes 1 on the clock edge after which the fill level is 32 or more. It never rises while the level is below 32.
- R5: Once set, `inhibit` stays 1 while the level is between 1 and 31. It returns to 0 on the edge after which the level is 0.
- R6: While the level is 56 or more, a pushed word is admitted only if bits [31:28] equal 4'hA (group leader) or 4'hD (group trailer). Any other value in bits [31:28], including the data code 4'h3, is discarded. Below level 56, every pushed word is admitted.
- R7: At level 64, a push with no pop in the same cycle is discarded and sets `overflow`. `overflow` stays 1 until reset.
- R8: A push and a pop in the same cycle are allowed at any level, including 64. When the pushed word is admitted, the level is unchanged. When the word is discarded by the R6 rule, the level drops by one. This case never sets `overflow`.
- R9: `pop_req` while `empty`=1 has no effect on contents or flags.
- R10: Asserting `rst` during operation discards all stored words and clears `inhibit` and `overflow` by the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high global reset |
| push_valid | input | 1 | A word from the serial receiver is offered this cycle |
| push_data | input | 32 | Offered word; bits [31:28] carry its kind |
| pop_req | input | 1 | Memory writer takes the oldest word this cycle |
| pop_data | output | 32 | Oldest stored word (show-ahead) |
| empty | output | 1 | No word stored |
| half_full | output | 1 | Fill level is 32 or more |
| inhibit | output | 1 | Trigger hold-off with half-full set and empty release |
| overflow | output | 1 | Sticky: a word was lost because the buffer was full |

## Verification
A wrong fill count shows at the ports within one cycle as a misplaced `empty` or `half_full` edge. It also shows, when the buffer is drained, as a missing, repeated or reordered word on `pop_data`. A broken hysteresis state shows as `inhibit` dropping before the buffer is empty, or rising below half full, on the very edge where the level crosses. A wrong admission decision near the high watermark stays invisible until the drain reaches that word. At that point, the word sequence read back differs from the sequence predicted by the leader/trailer rule.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    localparam int unsigned FWB_WIDTH      = 32;
    localparam int unsigned FWB_DEPTH      = 64;
    localparam int unsigned FWB_FILTER_LVL = 56;

    localparam logic [3:0] KIND_DATA    = 4'h3;
    localparam logic [3:0] KIND_LEADER  = 4'hA;
    localparam logic [3:0] KIND_TRAILER = 4'hD;

    // Outcome of offering one word to the buffer
    typedef struct packed {
        logic accept;       // word is written this cycle
        logic full_drop;    // word lost because every entry is occupied
        logic filter_drop;  // word discarded by the high-watermark rule
    } fwb_admit_t;

    function automatic logic is_boundary(input logic [3:0] kind);
        return (kind == KIND_LEADER) || (kind == KIND_TRAILER);
    endfunction

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/fwb_admit.sv
module fwb_admit
    import fwb_pkg::*;
#(
    parameter int unsigned DEPTH      = FWB_DEPTH,
    parameter int unsigned FILTER_LVL = FWB_FILTER_LVL,
    parameter int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             push_valid,
    input  logic [3:0]       push_kind,
    input  logic [CNT_W-1:0] level,
    input  logic             pop_fire,
    output fwb_admit_t       decision
);

    logic room_ok;
    logic kind_ok;

    // A pop in the same cycle frees the entry the push needs
    assign room_ok = (level < CNT_W'(DEPTH)) || pop_fire;

    generate
        if (FILTER_LVL < DEPTH) begin : g_filter
            assign kind_ok = (level < CNT_W'(FILTER_LVL)) || is_boundary(push_kind);
        end else begin : g_nofilter
            assign kind_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        decision             = '0;
        decision.accept      = push_valid && room_ok && kind_ok;
        decision.full_drop   = push_valid && !room_ok;
        decision.filter_drop = push_valid && room_ok && !kind_ok;
    end

endmodule

// File: rtl/fwb_store.sv
module fwb_store
    import fwb_pkg::*;
#(
    parameter int unsigned WIDTH = FWB_WIDTH,
    parameter int unsigned DEPTH = FWB_DEPTH,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] level_next
);

    localparam int unsigned AW = ptr_bits(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        level_next = level;
        case ({wr_en, rd_en})
            2'b10:   level_next = level + 1'b1;
            2'b01:   level_next = level - 1'b1;
            default: level_next = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            level <= level_next;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/fwb_hyst.sv
module fwb_hyst #(
    parameter int unsigned CNT_W    = 7,
    parameter int unsigned HALF_LVL = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] level_next,
    output logic             hold
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= 1'b0;
        end else if (level_next >= CNT_W'(HALF_LVL)) begin
            hold <= 1'b1;
        end else if (level_next == '0) begin
            hold <= 1'b0;
        end
    end

endmodule

// File: rtl/frontend_word_buffer.sv
module frontend_word_buffer
    import fwb_pkg::*;
#(
    parameter int unsigned WIDTH      = FWB_WIDTH,
    parameter int unsigned DEPTH      = FWB_DEPTH,
    parameter int unsigned FILTER_LVL = FWB_FILTER_LVL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             half_full,
    output logic             inhibit,
    output logic             overflow
);

    localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
    localparam int unsigned HALF_LVL = DEPTH / 2;

    logic [CNT_W-1:0] fill_count;
    logic [CNT_W-1:0] fill_next;
    logic             pop_fire;
    fwb_admit_t       decision;

    assign pop_fire = pop_req && (fill_count != '0);

    fwb_admit #(
        .DEPTH     (DEPTH),
        .FILTER_LVL(FILTER_LVL),
        .CNT_W     (CNT_W)
    ) u_admit (
        .push_valid(push_valid),
        .push_kind (push_data[WIDTH-1 -: 4]),
        .level     (fill_count),
        .pop_fire  (pop_fire),
        .decision  (decision)
    );

    fwb_store #(
        .WIDTH(WIDTH),
        .DEPTH(DEPTH),
        .CNT_W(CNT_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (decision.accept),
        .wr_data   (push_data),
        .rd_en     (pop_fire),
        .rd_data   (pop_data),
        .level     (fill_count),
        .level_next(fill_next)
    );

    fwb_hyst #(
        .CNT_W   (CNT_W),
        .HALF_LVL(HALF_LVL)
    ) u_hyst (
        .clk       (clk),
        .rst       (rst),
        .level_next(fill_next),
        .hold      (inhibit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if (decision.full_drop) begin
            overflow <= 1'b1;
        end
    end

    assign empty     = (fill_count == '0);
    assign half_full = (fill_count >= CNT_W'(HALF_LVL));

endmodule

// File: rtl/fwb_checker.sv
module fwb_checker
    import fwb_pkg::*;
#(
    parameter int unsigned WIDTH      = FWB_WIDTH,
    parameter int unsigned DEPTH      = FWB_DEPTH,
    parameter int unsigned FILTER_LVL = FWB_FILTER_LVL,
    parameter int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_valid,
    input logic [WIDTH-1:0] push_data,
    input logic             pop_req,
    input logic             empty,
    input logic             half_full,
    input logic             inhibit,
    input logic             overflow,
    input logic [CNT_W-1:0] count
);

    logic bnd;
    assign bnd = is_boundary(push_data[WIDTH-1 -: 4]);

    // R4: level at or above half always has the hold-off raised
    assert_inhibit_at_half_R4: assert property (@(posedge clk) disable iff (rst)
        half_full |-> inhibit);

    // R4: hold-off only rises together with half full
    assert_inhibit_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !inhibit |=> (!inhibit || half_full));

    // R5: hold-off only falls when the buffer is drained
    assert_inhibit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (inhibit || empty));

    // R5: drained buffer has no hold-off
    assert_inhibit_clear_R5: assert property (@(posedge clk) disable iff (rst)
        empty |-> !inhibit);

    // R6: ordinary words above the watermark never raise the level
    assert_filter_R6: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !bnd && count >= CNT_W'(FILTER_LVL)) |=> (count <= $past(count)));

    // R7: push into a full buffer without pop is recorded
    assert_overflow_set_R7: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !pop_req && count == CNT_W'(DEPTH)) |=> overflow);

    // R7: loss flag is sticky
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R8: admitted push with pop keeps the level
    assert_pushpop_level_R8: assert property (@(posedge clk) disable iff (rst)
        (push_valid && pop_req && !empty && (bnd || count < CNT_W'(FILTER_LVL)))
        |=> $stable(count));

    // R9: pop on empty changes nothing
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (empty && !push_valid) |=> empty);

endmodule

bind frontend_word_buffer fwb_checker #(
    .WIDTH     (WIDTH),
    .DEPTH     (DEPTH),
    .FILTER_LVL(FILTER_LVL),
    .CNT_W     (CNT_W)
) u_fwb_checker (
    .clk       (clk),
    .rst       (rst),
    .push_valid(push_valid),
    .push_data (push_data),
    .pop_req   (pop_req),
    .empty     (empty),
    .half_full (half_full),
    .inhibit   (inhibit),
    .overflow  (overflow),
    .count     (fill_count)
);

// File: tb/frontend_word_buffer_test.sv
module frontend_word_buffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int HALF       = 32;
    localparam int FILT       = 56;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [31:0] push_data  = '0;
    logic        pop_req    = 1'b0;
    logic [31:0] pop_data;
    logic        empty, half_full, inhibit, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] model[$];
    logic        m_inh = 1'b0;
    logic        m_ovf = 1'b0;
    logic [31:0] lfsr  = 32'h1D87_2A55;

    always #(CLK_PERIOD/2) clk = ~clk;

    frontend_word_buffer uut (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data),
        .empty(empty), .half_full(half_full),
        .inhibit(inhibit), .overflow(overflow)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // One clock cycle with the given stimulus and full status comparison
    task automatic do_cycle(input string tag, input logic pv,
                            input logic [31:0] pd, input logic pr);
        int   lvl;
        logic fire, bnd, acc;
        @(negedge clk);
        lvl = model.size();
        if (lvl > 0) chk(tag, "pop_data", pop_data, model[0]);
        push_valid = pv; push_data = pd; pop_req = pr;
        fire = pr && (lvl > 0);
        bnd  = (pd[31:28] == 4'hA) || (pd[31:28] == 4'hD);
        acc  = pv && (lvl < FILT || bnd) && (lvl < DEPTH || fire);
        if (pv && lvl == DEPTH && !fire) m_ovf = 1'b1;
        if (fire) void'(model.pop_front());
        if (acc) model.push_back(pd);
        lvl = model.size();
        if (lvl >= HALF) m_inh = 1'b1;
        else if (lvl == 0) m_inh = 1'b0;
        @(posedge clk);
        #1;
        push_valid = 1'b0; pop_req = 1'b0;
        chk(tag, "empty",     {31'd0, empty},     {31'd0, lvl == 0});
        chk(tag, "half_full", {31'd0, half_full}, {31'd0, lvl >= HALF});
        chk(tag, "inhibit",   {31'd0, inhibit},   {31'd0, m_inh});
        chk(tag, "overflow",  {31'd0, overflow},  {31'd0, m_ovf});
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R10", "empty in reset", {31'd0, empty}, 32'd1);
        @(negedge clk);
        rst = 1'b0;
        model.delete();
        m_inh = 1'b0;
        m_ovf = 1'b0;
    endtask

    function automatic logic [31:0] word(input logic [3:0] kind, input int seq);
        return {kind, 28'(seq * 32'h0013_579B + 7)};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "empty",     {31'd0, empty},     32'd1);
        chk("R1", "half_full", {31'd0, half_full}, 32'd0);
        chk("R1", "inhibit",   {31'd0, inhibit},   32'd0);
        chk("R1", "overflow",  {31'd0, overflow},  32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "empty after release", {31'd0, empty}, 32'd1);
        chk("R1", "inhibit after release", {31'd0, inhibit}, 32'd0);

        // R9: pops on an empty buffer
        for (int i = 0; i < 3; i++) do_cycle("R9", 1'b0, '0, 1'b1);

        // R3/R4: fill with data words to the hold-off threshold
        for (int i = 0; i < HALF; i++) do_cycle("R3/R4", 1'b1, word(4'h3, i), 1'b0);
        // R3: continue to the high watermark
        for (int i = HALF; i < FILT; i++) do_cycle("R3", 1'b1, word(4'h3, i), 1'b0);

        // R6: every kind code offered at the watermark
        for (int k = 0; k < 16; k++) do_cycle("R6", 1'b1, word(4'(k), 100 + k), 1'b0);
        // R6: top up with alternating leaders and trailers and some data
        for (int i = 0; i < 10; i++)
            do_cycle("R6", 1'b1, word((i % 3 == 0) ? 4'h3 : ((i % 2 == 0) ? 4'hA : 4'hD), 200 + i), 1'b0);

        // R7: buffer is full now; any push without pop is lost
        do_cycle("R7", 1'b1, word(4'hA, 300), 1'b0);
        do_cycle("R7", 1'b1, word(4'h3, 301), 1'b0);
        do_cycle("R7", 1'b0, '0, 1'b0);

        // R8: push and pop together at full and just below
        do_cycle("R8", 1'b1, word(4'hD, 400), 1'b1);
        do_cycle("R8", 1'b1, word(4'h3, 401), 1'b1);
        do_cycle("R8", 1'b1, word(4'hA, 402), 1'b1);
        do_cycle("R8", 1'b1, word(4'h3, 403), 1'b1);

        // R5: drain below half; hold-off remains until empty
        while (model.size() > 20) do_cycle("R2/R5", 1'b0, '0, 1'b1);
        for (int i = 0; i < 5; i++) do_cycle("R5", 1'b1, word(4'h3, 500 + i), 1'b0);
        while (model.size() > 0) do_cycle("R2/R5", 1'b0, '0, 1'b1);
        do_cycle("R5", 1'b0, '0, 1'b0);

        // R8: push and pop together below the watermark
        for (int i = 0; i < 4; i++) do_cycle("R8", 1'b1, word(4'h3, 600 + i), 1'b0);
        for (int i = 0; i < 6; i++) do_cycle("R8", 1'b1, word(4'h3, 610 + i), 1'b1);

        // R10: reset during operation with hold-off and overflow set
        while (model.size() < DEPTH) do_cycle("R10", 1'b1, word(4'hA, 700 + model.size()), 1'b0);
        do_cycle("R10", 1'b1, word(4'hD, 800), 1'b0);
        apply_reset();
        @(posedge clk);
        #1;
        chk("R10", "empty",    {31'd0, empty},    32'd1);
        chk("R10", "inhibit",  {31'd0, inhibit},  32'd0);
        chk("R10", "overflow", {31'd0, overflow}, 32'd0);
        do_cycle("R10", 1'b1, word(4'h3, 900), 1'b0);
        do_cycle("R10", 1'b0, '0, 1'b1);

        // R2: long pseudo-random sweep across all levels and kind codes
        for (int c = 0; c < 6000; c++) begin
            logic pv, pr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pv = lfsr[0] | lfsr[7];
            if ((c / 750) % 2 == 0) pr = lfsr[3] & lfsr[5];
            else                    pr = lfsr[3] | lfsr[5];
            do_cycle("R2", pv, {lfsr[11:8], lfsr[27:0] ^ 28'(c)}, pr);
        end
        while (model.size() > 0) do_cycle("R2", 1'b0, '0, 1'b1);

        finish_run();
    end

endmodule